// File: doc/BRIEF.md
# Shared Coherence Directory Controller

This block is the shared second-level coherence point for four private caches. For every line address it keeps one directory entry: the line's data, a flag that says whether the controller holds a copy, an owner field that names the one cache holding the line Exclusive or Modified, and a four-bit vector of caches holding it Shared. The private caches send it two kinds of request, one asking for ownership and one asking for a shared copy. The controller answers each request with a grant that carries data and a permission level.

When the directory shows other holders that must give up or downgrade the line, the controller snoops only those caches. It uses a snoop-invalidate for an ownership request and a snoop-share for a shared request. It waits until every snooped cache has acknowledged. Dirty data that comes back with an acknowledgement replaces the controller's copy. When the controller holds no copy, it reads a fixed-latency memory port. It services one request at a time and picks among waiting caches in round-robin order. A line that was cached nowhere is granted Shared on a shared request, never Exclusive.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset no grant, snoop or memory read is issued, and every line is uncached, so the first request to any address reads memory.
- R2: A request for a line held by no cache and not held by the controller issues exactly one memory read at that address. The read is a one-cycle `mem_rd`, in the cycle after the second rising edge at which the request is present. The grant carries `mem_rdata` sampled MEM_LAT cycles later and appears in the cycle after that.
- R3: A share request (`req_rfo`=0) for a line that is valid and has no owner is granted in the cycle after the second rising edge that sees the request, with `gnt_excl`=0, the stored data, no snoop and no memory read.
- R4: A share request for a line that another cache owns sends a snoop-share (`snp_inv`=0) to that one cache only. The snoop is held until that cache's `snp_ack`. The Shared grant follows in the cycle after the acknowledgement is sampled.
- R5: After a snoop-share both the previous owner and the requester are recorded as sharers, so a later ownership request from a third cache snoop-invalidates both.
- R6: An ownership request (`req_rfo`=1) snoop-invalidates (`snp_inv`=1) every other cache recorded as owner or sharer, all at once. Each `snp_valid` bit stays high until that cache acknowledges. The Exclusive grant (`gnt_excl`=1) appears in the cycle after the last acknowledgement is sampled.
- R7: After an Exclusive grant the requester is the sole recorded holder, so a later share request from another cache snoops only that cache.
- R8: An ownership request from a cache already listed as a sharer never snoops that cache. If it is the only sharer, the request is granted with data and no snoop at all.
- R9: An ownership request for an uncached line reads memory and grants the memory data with Exclusive permission.
- R10: Data returned with an acknowledgement whose `snp_dirty` bit is set replaces the controller's copy before the grant. Acknowledgements without `snp_dirty` leave the copy unchanged.
- R11: Arbitration is round-robin. Priority starts at cache 0 after reset and moves to cache i+1 (mod 4) after cache i is accepted.
- R12: At most one grant bit is set at a time. A request is accepted only after the previous grant has been sent, so back-to-back direct grants are exactly three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_CACHE | Per-cache request, held until that cache's grant |
| req_rfo | input | N_CACHE | Per-cache request kind: 1 ownership, 0 shared copy |
| req_addr | input | N_CACHE*ADDR_W | Per-cache line address, cache i in slice i |
| gnt_valid | output | N_CACHE | One-hot grant pulse to the requester |
| gnt_excl | output | 1 | Grant permission: 1 Exclusive, 0 Shared |
| gnt_data | output | DATA_W | Line data carried by the grant |
| snp_valid | output | N_CACHE | Snoop request mask, each bit held until acknowledged |
| snp_inv | output | 1 | Snoop kind: 1 invalidate, 0 downgrade to Shared |
| snp_addr | output | ADDR_W | Line address being snooped |
| snp_ack | input | N_CACHE | Per-cache snoop acknowledgement pulse |
| snp_dirty | input | N_CACHE | Acknowledgement carries modified data |
| snp_data | input | N_CACHE*DATA_W | Per-cache data returned with the acknowledgement |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, sampled MEM_LAT cycles after the strobe |

## Verification
The bench drives ownership requests against lines with two sharers and staggers their acknowledgements. A controller that granted after the first acknowledgement, or that dropped a snoop bit before its acknowledgement, would show the wrong mask or an early grant in a specific cycle. Dirty and clean acknowledgements are mixed, and clean ones carry garbage data, so a design that merged every acknowledgement, or none, returns the wrong line value. The bench also checks the sharer-upgrade case, where self-snooping would show up as an unexpected snoop bit. Finally, simultaneous requests from all four caches expose a fixed-priority arbiter or one that accepts a request while a transaction is in flight.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SNOOP,
    ST_MEM,
    ST_GRANT
  } ctl_state_e;

endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic          fire,
  output logic [IW-1:0] win_id
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          found;
  int unsigned   idx;

  always_comb begin
    found  = 1'b0;
    win_id = '0;
    idx    = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req[idx]) begin
        found  = 1'b1;
        win_id = IW'(idx);
      end
    end
  end

  assign fire = en & found;

  always_comb begin
    ptr_d = ptr_q;
    if (fire) ptr_d = IW'((int'(win_id) + 1) % N);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (fire) ptr_q <= ptr_d;
  end

  // R11: the winner is always a cache that is requesting
  assert_arb_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> req[win_id]);

endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rd_own_v,
  output logic [IW-1:0] rd_own_id,
  output logic [N-1:0]  rd_shr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_valid,
  input  logic          wr_own_v,
  input  logic [IW-1:0] wr_own_id,
  input  logic [N-1:0]  wr_shr,
  input  logic [DW-1:0] wr_data
);

  localparam int NL = 1 << AW;

  logic [NL-1:0] vld_q;
  logic [NL-1:0] ownv_q;
  logic [IW-1:0] ownid_q [NL];
  logic [N-1:0]  shr_q   [NL];
  logic [DW-1:0] data_q  [NL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      ownv_q <= '0;
      for (int i = 0; i < NL; i++) begin
        ownid_q[i] <= '0;
        shr_q[i]   <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_addr]   <= wr_valid;
      ownv_q[wr_addr]  <= wr_own_v;
      ownid_q[wr_addr] <= wr_own_id;
      shr_q[wr_addr]   <= wr_shr;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_addr] <= wr_data;
  end

  assign rd_valid  = vld_q[rd_addr];
  assign rd_own_v  = ownv_q[rd_addr];
  assign rd_own_id = ownid_q[rd_addr];
  assign rd_shr    = shr_q[rd_addr];
  assign rd_data   = data_q[rd_addr];

  // R7: an entry written with an owner lists no sharers
  assert_owner_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_own_v) |-> (wr_shr == '0));

  // R9: an owned line always has a copy in the directory
  assert_owned_has_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_own_v |-> rd_valid);

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int MEM_LAT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CACHE-1:0]         req_valid,
  input  logic [N_CACHE-1:0]         req_rfo,
  input  logic [N_CACHE*ADDR_W-1:0]  req_addr,
  output logic [N_CACHE-1:0]         gnt_valid,
  output logic                       gnt_excl,
  output logic [DATA_W-1:0]          gnt_data,
  output logic [N_CACHE-1:0]         snp_valid,
  output logic                       snp_inv,
  output logic [ADDR_W-1:0]          snp_addr,
  input  logic [N_CACHE-1:0]         snp_ack,
  input  logic [N_CACHE-1:0]         snp_dirty,
  input  logic [N_CACHE*DATA_W-1:0]  snp_data,
  output logic                       mem_rd,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic [DATA_W-1:0]          mem_rdata
);

  localparam int IW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1;
  localparam int CW = $clog2(MEM_LAT + 1);
  localparam logic [CW-1:0] LAT_LAST = CW'(MEM_LAT - 1);

  function automatic logic [N_CACHE-1:0] dec(input logic [IW-1:0] i);
    logic [N_CACHE-1:0] r;
    r    = '0;
    r[i] = 1'b1;
    return r;
  endfunction

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  ctl_state_e          state_q, state_d;
  logic [IW-1:0]       id_q;
  logic                rfo_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                lv_q, lv_d;
  logic                lov_q, lov_d;
  logic [IW-1:0]       loid_q, loid_d;
  logic [N_CACHE-1:0]  ls_q, ls_d;
  logic [DATA_W-1:0]   ld_q, ld_d;
  logic [N_CACHE-1:0]  pend_q, pend_d;
  logic [CW-1:0]       cnt_q, cnt_d;

  logic                arb_fire;
  logic [IW-1:0]       arb_id;
  logic                tbl_valid, tbl_own_v;
  logic [IW-1:0]       tbl_own_id;
  logic [N_CACHE-1:0]  tbl_shr;
  logic [DATA_W-1:0]   tbl_data;
  logic [N_CACHE-1:0]  self_bit, tbl_own_bit, look_tgt, wr_shr;
  logic                wr_en, ld_en;

  coh_rr_arb #(.N(N_CACHE), .IW(IW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .en     (state_q == ST_IDLE),
    .req    (req_valid),
    .fire   (arb_fire),
    .win_id (arb_id)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      id_q   <= '0;
      rfo_q  <= 1'b0;
      addr_q <= '0;
    end else if (arb_fire) begin
      id_q   <= arb_id;
      rfo_q  <= req_rfo[arb_id];
      addr_q <= req_addr[int'(arb_id)*ADDR_W +: ADDR_W];
    end
  end

  coh_dir_table #(.N(N_CACHE), .IW(IW), .AW(ADDR_W), .DW(DATA_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .rd_addr   (addr_q),
    .rd_valid  (tbl_valid),
    .rd_own_v  (tbl_own_v),
    .rd_own_id (tbl_own_id),
    .rd_shr    (tbl_shr),
    .rd_data   (tbl_data),
    .wr_en     (wr_en),
    .wr_addr   (addr_q),
    .wr_valid  (lv_q),
    .wr_own_v  (rfo_q),
    .wr_own_id (id_q),
    .wr_shr    (wr_shr),
    .wr_data   (ld_q)
  );

  assign self_bit    = dec(id_q);
  assign tbl_own_bit = tbl_own_v ? dec(tbl_own_id) : '0;
  assign look_tgt    = rfo_q ? ((tbl_shr | tbl_own_bit) & ~self_bit)
                             : (tbl_own_bit & ~self_bit);

  always_comb begin
    state_d = state_q;
    lv_d    = lv_q;
    lov_d   = lov_q;
    loid_d  = loid_q;
    ls_d    = ls_q;
    ld_d    = ld_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (arb_fire) state_d = ST_LOOK;
      ST_LOOK: begin
        lv_d   = tbl_valid;
        lov_d  = tbl_own_v;
        loid_d = tbl_own_id;
        ls_d   = tbl_shr;
        ld_d   = tbl_data;
        pend_d = look_tgt;
        cnt_d  = '0;
        if (look_tgt != '0)  state_d = ST_SNOOP;
        else if (!tbl_valid) state_d = ST_MEM;
        else                 state_d = ST_GRANT;
      end
      ST_SNOOP: begin
        for (int i = 0; i < N_CACHE; i++) begin
          if (pend_q[i] && snp_ack[i] && snp_dirty[i])
            ld_d = snp_data[i*DATA_W +: DATA_W];
        end
        pend_d = pend_q & ~snp_ack;
        if (pend_d == '0) state_d = ST_GRANT;
      end
      ST_MEM: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAT_LAST) begin
          ld_d    = mem_rdata;
          lv_d    = 1'b1;
          state_d = ST_GRANT;
        end
      end
      ST_GRANT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign ld_en = (state_q == ST_LOOK) || (state_q == ST_SNOOP) || (state_q == ST_MEM);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      lv_q    <= 1'b0;
      lov_q   <= 1'b0;
      loid_q  <= '0;
      ls_q    <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      lv_q    <= lv_d;
      lov_q   <= lov_d;
      loid_q  <= loid_d;
      ls_q    <= ls_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) ld_q <= ld_d;
  end

  assign wr_en  = (state_q == ST_GRANT);
  assign wr_shr = rfo_q ? '0 : (ls_q | self_bit | (lov_q ? dec(loid_q) : '0));

  assign gnt_valid = (state_q == ST_GRANT) ? self_bit : '0;
  assign gnt_excl  = rfo_q;
  assign gnt_data  = ld_q;
  assign snp_valid = (state_q == ST_SNOOP) ? pend_q : '0;
  assign snp_inv   = rfo_q;
  assign snp_addr  = addr_q;
  assign mem_rd    = (state_q == ST_MEM) && (cnt_q == '0);
  assign mem_addr  = addr_q;

  // R12: never more than one grant, never two in a row
  assert_one_grant_R12: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(gnt_valid));
  assert_grant_gap_R12: assert property (@(posedge clk) disable iff (!rst_n_i)
    (gnt_valid != '0) |=> (gnt_valid == '0));
  // R6: a grant is never sent while a snoop is outstanding
  assert_grant_after_acks_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (gnt_valid != '0) |-> (snp_valid == '0));
  // R8: the requester is never snooped for its own request
  assert_no_self_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((snp_valid & self_bit) == '0));
  // R4: a downgrade snoop targets exactly one cache
  assert_share_snoop_one_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((snp_valid != '0) && !snp_inv) |-> $onehot(snp_valid));
  // R2: memory read is a single-cycle strobe
  assert_mem_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_rd |=> !mem_rd);
  // R9: every grant carries a valid line
  assert_grant_has_line_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_GRANT) |-> lv_q);

endmodule

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int ML = 4;
  localparam int NL = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N-1:0]      req_valid, req_rfo;
  logic [N*AW-1:0]   req_addr;
  logic [N-1:0]      gnt_valid;
  logic              gnt_excl;
  logic [DW-1:0]     gnt_data;
  logic [N-1:0]      snp_valid;
  logic              snp_inv;
  logic [AW-1:0]     snp_addr;
  logic [N-1:0]      snp_ack, snp_dirty;
  logic [N*DW-1:0]   snp_data;
  logic              mem_rd;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_dir_ctrl #(.N_CACHE(N), .ADDR_W(AW), .DATA_W(DW), .MEM_LAT(ML)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_rfo(req_rfo), .req_addr(req_addr),
    .gnt_valid(gnt_valid), .gnt_excl(gnt_excl), .gnt_data(gnt_data),
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .snp_ack(snp_ack), .snp_dirty(snp_dirty), .snp_data(snp_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] memf(input int a);
    return 16'h1000 + DW'(a) * 16'h0111;
  endfunction

  assign mem_rdata = memf(int'(mem_addr));

  // behavioural reference state
  bit            m_valid [NL];
  int            m_owner [NL];
  logic [N-1:0]  m_shr   [NL];
  logic [DW-1:0] m_data  [NL];
  bit            c_dirty [N][NL];
  logic [DW-1:0] c_val   [N][NL];
  int            rr_ptr;
  int            wval;
  int            n_chk, n_fail;
  bit            finished;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic xact(input int id, input bit rfo, input int a, input int dly,
                      input string tag);
    logic [N-1:0]  self, own, tgt, exp_snp;
    logic [DW-1:0] d;
    bit            use_mem;
    int            ackc [N];
    int            k, gc, last;
    self = N'(1) << id;
    own  = (m_owner[a] >= 0) ? (N'(1) << m_owner[a]) : '0;
    tgt  = rfo ? ((m_shr[a] | own) & ~self) : (own & ~self);
    use_mem = (tgt == '0) && !m_valid[a];
    k = 0; last = 0;
    for (int j = 0; j < N; j++) begin
      ackc[j] = -1;
      if (tgt[j]) begin ackc[j] = 2 + dly + k; last = ackc[j]; k++; end
    end
    gc = (tgt != '0) ? last + 1 : (use_mem ? 2 + ML : 2);
    d = use_mem ? memf(a) : m_data[a];
    for (int j = 0; j < N; j++) if (tgt[j] && c_dirty[j][a]) d = c_val[j][a];

    @(negedge clk);
    req_valid[id] = 1'b1;
    req_rfo[id]   = rfo;
    req_addr[id*AW +: AW] = a[AW-1:0];
    for (int c = 1; c <= gc; c++) begin
      @(negedge clk);
      snp_ack = '0; snp_dirty = '0;
      exp_snp = '0;
      if (c >= 2) for (int j = 0; j < N; j++) if (tgt[j] && ackc[j] >= c) exp_snp[j] = 1'b1;
      chk(tag, "snoop mask", 32'(snp_valid), 32'(exp_snp));
      chk(tag, "grant", 32'(gnt_valid), (c == gc) ? 32'(self) : 32'h0);
      chk(tag, "mem read", 32'(mem_rd), 32'(use_mem && c == 2));
      if (c == 2 && tgt != '0) begin
        chk(tag, "snoop kind", 32'(snp_inv), 32'(rfo));
        chk(tag, "snoop addr", 32'(snp_addr), 32'(a));
      end
      if (c == 2 && use_mem) chk(tag, "mem addr", 32'(mem_addr), 32'(a));
      if (c == gc) begin
        chk(tag, "permission", 32'(gnt_excl), 32'(rfo));
        chk(tag, "grant data", 32'(gnt_data), 32'(d));
        req_valid[id] = 1'b0;
      end
      for (int j = 0; j < N; j++) begin
        if (ackc[j] == c) begin
          snp_ack[j]   = 1'b1;
          snp_dirty[j] = c_dirty[j][a];
          snp_data[j*DW +: DW] = c_dirty[j][a] ? c_val[j][a] : 16'hDEAD;
        end
      end
    end
    for (int j = 0; j < N; j++) if (tgt[j]) c_dirty[j][a] = 1'b0;
    m_data[a]  = d;
    m_valid[a] = 1'b1;
    if (rfo) begin
      m_owner[a] = id;
      m_shr[a]   = '0;
      wval++;
      c_val[id][a]   = 16'hA000 + DW'(wval);
      c_dirty[id][a] = 1'b1;
    end else begin
      m_shr[a]   = m_shr[a] | self | own;
      m_owner[a] = -1;
    end
    rr_ptr = (id + 1) % N;
  endtask

  // caches j in mask request a shared copy of line 4+j together
  task automatic rr_burst(input logic [N-1:0] mask);
    logic [N-1:0] rem, exp_g;
    int nextg, w;
    @(negedge clk);
    for (int j = 0; j < N; j++) if (mask[j]) begin
      req_valid[j] = 1'b1; req_rfo[j] = 1'b0; req_addr[j*AW +: AW] = AW'(4 + j);
    end
    rem = mask; nextg = 2;
    for (int c = 1; rem != '0 && c <= 40; c++) begin
      @(negedge clk);
      exp_g = '0; w = 0;
      if (c == nextg) begin
        for (int k = 0; k < N; k++) begin
          if (exp_g == '0 && rem[(rr_ptr + k) % N]) begin
            w = (rr_ptr + k) % N; exp_g = N'(1) << w;
          end
        end
        chk("R11", "round-robin winner", 32'(gnt_valid), 32'(exp_g));
        chk("R11", "burst data", 32'(gnt_data), 32'(m_data[4 + w]));
        req_valid[w] = 1'b0;
        rem[w] = 1'b0;
        m_shr[4 + w] = m_shr[4 + w] | exp_g;
        rr_ptr = (w + 1) % N;
        nextg = c + 3;
      end else begin
        chk("R12", "no grant between transactions", 32'(gnt_valid), 32'h0);
      end
    end
    chk("R11", "all burst requests served", 32'(rem), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0; rr_ptr = 0; wval = 0;
    for (int a = 0; a < NL; a++) begin
      m_valid[a] = 1'b0; m_owner[a] = -1; m_shr[a] = '0; m_data[a] = '0;
      for (int j = 0; j < N; j++) begin c_dirty[j][a] = 1'b0; c_val[j][a] = '0; end
    end
    rst_n = 1'b0;
    req_valid = '0; req_rfo = '0; req_addr = '0;
    snp_ack = '0; snp_dirty = '0; snp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "reset grant", 32'(gnt_valid), 32'h0);
      chk("R1", "reset snoop", 32'(snp_valid), 32'h0);
      chk("R1", "reset mem read", 32'(mem_rd), 32'h0);
    end

    xact(0, 1'b0, 1, 0, "R2");   // first touch after reset: memory, Shared
    xact(1, 1'b0, 1, 0, "R3");   // shared hit, no snoop
    xact(2, 1'b1, 1, 1, "R6");   // invalidate two sharers, staggered acks
    xact(3, 1'b0, 1, 2, "R4");   // downgrade dirty owner
    xact(0, 1'b1, 1, 0, "R5");   // both former holders invalidated
    xact(1, 1'b1, 1, 3, "R10");  // dirty data from invalidated owner
    xact(2, 1'b0, 1, 0, "R7");   // sole owner snooped
    xact(1, 1'b0, 2, 0, "R2");
    xact(1, 1'b1, 2, 0, "R8");   // sole sharer upgrades, no snoop
    xact(3, 1'b0, 3, 0, "R2");
    xact(2, 1'b0, 3, 0, "R3");
    xact(3, 1'b1, 3, 1, "R8");   // sharer upgrades, only other sharer snooped
    xact(2, 1'b1, 0, 0, "R9");   // ownership of uncached line
    xact(1, 1'b0, 0, 1, "R10");  // dirty merge on downgrade
    for (int j = 0; j < N; j++) xact(j, 1'b0, 4 + j, 0, "R1");
    xact(1, 1'b0, 5, 0, "R3");   // moves priority to cache 2
    rr_burst(4'b1111);
    rr_burst(4'b1010);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule